// File: doc/BRIEF.md
# Reusable Block Table

This block keeps a small store of freed heap blocks, sorted by allocation size, so that an allocation can be served from recycled memory rather than from fresh heap. When an object's reference count reaches zero, its block address and size are inserted. An allocation query names a size. One cycle later the block answers with the address of a free block of exactly that size, or with zero. A zero answer tells the software allocator to fall back to bump-pointer allocation.

Sizes are coded in granules. Sizes 1 to NC each own one size class, and each class holds DEPTH entries kept in last-in, first-out order. When a class overflows, its oldest entry is pushed out to a larger backing table through a valid/ready port. When a hit leaves a class empty, a refill request for that size is raised towards the backing table. The backing table answers with ordinary insertions.

Top module: `reusable_block_table`

## Requirements
- R1: An accepted insertion (ins_valid and ins_ready high) with non-zero address and size s in 1..NC stores the block in class s. A query with q_size equal to s returns that address on r_addr, with r_valid high, on the clock edge after the query. r_valid is high exactly one cycle after each query cycle.
- R2: A query returns r_addr = 0 when its class is empty or when q_size is 0 or greater than NC. r_addr is 0 whenever no query was presented in the previous cycle.
- R3: Within a class, the most recently inserted block is returned first. A hit removes the entry, so an address is handed out at most once per insertion.
- R4: An insertion whose address is 0, or whose size is 0 or greater than NC, is discarded and stores nothing.
- R5: An accepted insertion into a class that already holds DEPTH entries pushes out the oldest entry. ev_valid rises with that entry's address and size. ev_valid, ev_addr and ev_size hold until ev_ready is high.
- R6: ins_ready is low while an evicted entry waits (ev_valid high, ev_ready low). An insertion offered then is not taken.
- R7: When an insertion and a query for the same size are accepted in the same cycle, the insertion counts first. The query receives the inserted address, the class keeps its previous contents, and nothing is evicted.
- R8: A hit that empties a class (not a same-cycle pass-through) marks a refill request for that size. rf_valid stays high while any request is pending. rf_size shows the smallest pending size, and that request is cleared when rf_ready is high.
- R9: After reset all classes are empty, and r_valid, ev_valid and rf_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Insertion offered |
| ins_ready | output | 1 | Insertion can be taken |
| ins_addr | input | AW | Address of the freed block |
| ins_size | input | SW | Size of the freed block in granules |
| q_valid | input | 1 | Allocation query |
| q_size | input | SW | Requested size in granules |
| r_valid | output | 1 | Query result valid |
| r_addr | output | AW | Block address, or 0 for no block |
| ev_valid | output | 1 | Evicted entry towards backing table |
| ev_ready | input | 1 | Backing table takes the evicted entry |
| ev_addr | output | AW | Evicted block address |
| ev_size | output | SW | Evicted block size |
| rf_valid | output | 1 | Refill request pending |
| rf_ready | input | 1 | Backing table takes the refill request |
| rf_size | output | SW | Size to refill |

## Verification
An insertion and an allocation query can land in the same cycle. This matters most when both name the same size. The bench provokes that case on an empty class, on a full class and at random during a long mixed run. A behavioural queue model judges the result: the query must get the new address, the class contents must stay as they were, and no eviction may appear. Insertions that collide with a waiting eviction are also offered, to show they are held off rather than lost.

// File: rtl/reusable_block_table.sv
module reusable_block_table #(
  parameter int AW    = 32,
  parameter int SW    = 4,
  parameter int NC    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  output logic          ins_ready,
  input  logic [AW-1:0] ins_addr,
  input  logic [SW-1:0] ins_size,
  input  logic          q_valid,
  input  logic [SW-1:0] q_size,
  output logic          r_valid,
  output logic [AW-1:0] r_addr,
  output logic          ev_valid,
  input  logic          ev_ready,
  output logic [AW-1:0] ev_addr,
  output logic [SW-1:0] ev_size,
  output logic          rf_valid,
  input  logic          rf_ready,
  output logic [SW-1:0] rf_size
);
  localparam int CW = (NC > 1) ? $clog2(NC) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [AW-1:0] top_a [NC];
  logic [AW-1:0] bot_a [NC];
  logic [NW-1:0] cnt_a [NC];
  logic [NC-1:0] pend, pend_nxt;
  logic [CW-1:0] ins_cls, q_cls, rf_cls;
  logic ins_ok, q_ok, ins_fire, same, hit, byp;

  assign ins_ready = !ev_valid || ev_ready;
  assign ins_ok    = (ins_addr != '0) && (ins_size != '0) && (ins_size <= SW'(NC));
  assign q_ok      = (q_size != '0) && (q_size <= SW'(NC));
  assign ins_cls   = CW'(ins_size - SW'(1));
  assign q_cls     = CW'(q_size - SW'(1));
  assign ins_fire  = ins_valid && ins_ready && ins_ok;
  assign same      = ins_fire && (ins_cls == q_cls);
  assign hit       = q_valid && q_ok && ((cnt_a[q_cls] != '0) || same);
  assign byp       = hit && same;

  genvar c;
  generate
    for (c = 0; c < NC; c++) begin : g_cls
      logic [AW-1:0] s [DEPTH];
      logic [NW-1:0] n;
      logic ic, qc;
      assign ic = ins_fire && !byp && (ins_cls == CW'(c));
      assign qc = hit && !byp && (q_cls == CW'(c));
      assign top_a[c] = s[0];
      assign bot_a[c] = s[DEPTH-1];
      assign cnt_a[c] = n;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          n <= '0;
          for (int k = 0; k < DEPTH; k++) s[k] <= '0;
        end else if (ic) begin
          s[0] <= ins_addr;
          for (int k = 1; k < DEPTH; k++) s[k] <= s[k-1];
          if (n != NW'(DEPTH)) n <= n + NW'(1);
        end else if (qc) begin
          for (int k = 0; k < DEPTH - 1; k++) s[k] <= s[k+1];
          s[DEPTH-1] <= '0;
          n <= n - NW'(1);
        end
      end
    end
  endgenerate

  always_comb begin
    rf_cls = '0;
    for (int i = NC - 1; i >= 0; i--)
      if (pend[i]) rf_cls = CW'(i);
  end

  assign rf_valid = |pend;
  assign rf_size  = SW'(rf_cls) + SW'(1);

  always_comb begin
    pend_nxt = pend;
    if (rf_valid && rf_ready) pend_nxt[rf_cls] = 1'b0;
    if (hit && !byp && cnt_a[q_cls] == NW'(1)) pend_nxt[q_cls] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_valid  <= 1'b0;
      r_addr   <= '0;
      ev_valid <= 1'b0;
      ev_addr  <= '0;
      ev_size  <= '0;
      pend     <= '0;
    end else begin
      r_valid <= q_valid;
      r_addr  <= byp ? ins_addr : (hit ? top_a[q_cls] : '0);
      pend    <= pend_nxt;
      if (ins_fire && !byp && cnt_a[ins_cls] == NW'(DEPTH)) begin
        ev_valid <= 1'b1;
        ev_addr  <= bot_a[ins_cls];
        ev_size  <= ins_size;
      end else if (ev_ready) begin
        ev_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/reusable_block_table_chk.sv
module reusable_block_table_chk #(
  parameter int AW = 32,
  parameter int SW = 4,
  parameter int NC = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          q_valid,
  input logic [SW-1:0] q_size,
  input logic          r_valid,
  input logic [AW-1:0] r_addr,
  input logic          ev_valid,
  input logic          ev_ready,
  input logic [AW-1:0] ev_addr,
  input logic [SW-1:0] ev_size,
  input logic          rf_valid,
  input logic          rf_ready,
  input logic [SW-1:0] rf_size
);
  a_r1_result_follows_query: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> r_valid);

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |=> (!r_valid && r_addr == '0));

  a_r2_bad_size_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && (q_size == '0 || q_size > SW'(NC))) |=> (r_addr == '0));

  a_r5_evict_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_addr) && $stable(ev_size)));

  a_r5_evict_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (ev_addr != '0 && ev_size != '0 && ev_size <= SW'(NC)));

  a_r8_refill_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && !rf_ready) |=> rf_valid);

  a_r8_refill_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid |-> (rf_size != '0 && rf_size <= SW'(NC)));
endmodule

bind reusable_block_table reusable_block_table_chk #(.AW(AW), .SW(SW), .NC(NC)) u_chk (
  .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_size(q_size),
  .r_valid(r_valid), .r_addr(r_addr), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .ev_addr(ev_addr), .ev_size(ev_size), .rf_valid(rf_valid), .rf_ready(rf_ready),
  .rf_size(rf_size)
);

// File: tb/test_reusable_block_table.sv
`timescale 1ns/1ps
module test_reusable_block_table;
  localparam int AW = 32, SW = 4, NC = 8, DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          ins_valid = 1'b0, q_valid = 1'b0, ev_ready = 1'b1, rf_ready = 1'b1;
  logic [AW-1:0] ins_addr = '0;
  logic [SW-1:0] ins_size = '0, q_size = '0;
  logic          ins_ready, r_valid, ev_valid, rf_valid;
  logic [AW-1:0] r_addr, ev_addr;
  logic [SW-1:0] ev_size, rf_size;

  reusable_block_table #(.AW(AW), .SW(SW), .NC(NC), .DEPTH(DEPTH)) i_reusable_block_table (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_addr(ins_addr), .ins_size(ins_size), .q_valid(q_valid), .q_size(q_size),
    .r_valid(r_valid), .r_addr(r_addr), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_addr(ev_addr), .ev_size(ev_size), .rf_valid(rf_valid), .rf_ready(rf_ready),
    .rf_size(rf_size)
  );

  int checks = 0, fails = 0;
  string req = "R9";
  bit run = 1'b0;

  logic [AW-1:0] mq [NC][$];
  bit            m_rv = 1'b0, m_ev = 1'b0;
  logic [AW-1:0] m_ra = '0, m_ea = '0;
  logic [SW-1:0] m_es = '0;
  bit [NC-1:0]   m_pend = '0;
  bit            rdy, iok, qok, byp;
  int            ic, qc, lo;

  function automatic int lowest(bit [NC-1:0] p);
    for (int i = 0; i < NC; i++) if (p[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) mq[c].delete();
      m_rv = 0; m_ra = '0; m_ev = 0; m_pend = '0;
    end else begin
      rdy = !m_ev || ev_ready;
      iok = ins_valid && rdy && ins_addr != '0 && ins_size >= 1 && ins_size <= NC;
      qok = q_valid && q_size >= 1 && q_size <= NC;
      ic  = int'(ins_size) - 1;
      qc  = int'(q_size) - 1;
      byp = iok && qok && (ic == qc);
      lo  = lowest(m_pend);
      if (lo >= 0 && rf_ready) m_pend[lo] = 1'b0;
      if (m_ev && ev_ready) m_ev = 1'b0;
      m_rv = q_valid;
      m_ra = '0;
      if (byp) m_ra = ins_addr;
      else begin
        if (iok) begin
          if (mq[ic].size() == DEPTH) begin
            m_ev = 1'b1; m_ea = mq[ic].pop_back(); m_es = ins_size;
          end
          mq[ic].push_front(ins_addr);
        end
        if (qok && mq[qc].size() > 0) begin
          m_ra = mq[qc].pop_front();
          if (mq[qc].size() == 0) m_pend[qc] = 1'b1;
        end
      end
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      chk("r_valid", 64'(r_valid), 64'(m_rv));
      chk("r_addr", 64'(r_addr), 64'(m_ra));
      chk("ev_valid", 64'(ev_valid), 64'(m_ev));
      if (m_ev) begin
        chk("ev_addr", 64'(ev_addr), 64'(m_ea));
        chk("ev_size", 64'(ev_size), 64'(m_es));
      end
      chk("rf_valid", 64'(rf_valid), 64'(m_pend != '0));
      if (m_pend != '0) chk("rf_size", 64'(rf_size), 64'(lowest(m_pend) + 1));
      chk("ins_ready", 64'(ins_ready), 64'(!m_ev || ev_ready));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic ins(logic [AW-1:0] a, int s);
    ins_valid = 1; ins_addr = a; ins_size = SW'(s);
    tick(); ins_valid = 0;
  endtask

  task automatic qry(int s);
    q_valid = 1; q_size = SW'(s);
    tick(); q_valid = 0;
  endtask

  task automatic both(logic [AW-1:0] a, int s, int qs);
    ins_valid = 1; ins_addr = a; ins_size = SW'(s);
    q_valid = 1; q_size = SW'(qs);
    tick(); ins_valid = 0; q_valid = 0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    tick(2);
    req = "R9"; run = 1;
    tick(2);
    rst_n = 1;
    tick(2);

    req = "R1";
    for (int s = 1; s <= NC; s++) ins(32'h1000 * s, s);
    for (int s = NC; s >= 1; s--) qry(s);
    tick(2);

    req = "R2";
    qry(3); qry(0); qry(9); qry(15);
    tick();

    req = "R3";
    ins(32'hA0, 2); ins(32'hB0, 2); ins(32'hC0, 2);
    qry(2); qry(2); qry(2); qry(2);
    tick();

    req = "R4";
    ins(32'h0, 2); ins(32'h55, 0); ins(32'h66, 9); ins(32'h77, 15);
    qry(2); qry(1); qry(0);
    tick();

    req = "R5";
    ev_ready = 0;
    for (int i = 1; i <= 5; i++) ins(32'h300 + i, 3);
    req = "R6";
    ins(32'h3FF, 3); ins(32'h3EE, 5);
    tick(3);
    ev_ready = 1;
    tick(2);
    req = "R5";
    for (int i = 0; i < 6; i++) qry(3);
    qry(5);

    req = "R7";
    for (int i = 1; i <= 4; i++) ins(32'h400 + i, 4);
    both(32'h4AA, 4, 4);
    tick();
    for (int i = 0; i < 5; i++) qry(4);
    both(32'h5AA, 5, 5);
    qry(5);
    tick();

    req = "R8";
    rf_ready = 0;
    ins(32'h600, 6); ins(32'h700, 7);
    qry(7); qry(6);
    tick(4);
    rf_ready = 1;
    tick(3);

    req = "R1";
    for (int i = 0; i < 3000; i++) begin
      ins_valid = 1'($urandom_range(0, 1));
      ins_addr  = (($urandom_range(0, 15) == 0) ? 32'h0 : $urandom());
      ins_size  = SW'($urandom_range(0, 9));
      q_valid   = 1'($urandom_range(0, 1));
      q_size    = (($urandom_range(0, 3) == 0) ? ins_size : SW'($urandom_range(0, 9)));
      ev_ready  = ($urandom_range(0, 3) != 0);
      rf_ready  = ($urandom_range(0, 2) != 0);
      tick();
    end
    ins_valid = 0; q_valid = 0; ev_ready = 1; rf_ready = 1;
    tick(12);
    finish_run();
  end
endmodule